// File: doc/BRIEF.md
# Banked Deep Memory with Selectable Output Merge

This block is a deep single-clock memory with one read/write port. It is built from a power-of-two number of identical shallow banks. The upper address bits choose a bank and the remaining bits index a word inside that bank. Only the addressed bank takes part in an access.

Each bank holds its own read register. The bank index of every read is registered alongside that read. A merge network then uses the registered index to pick the right bank's word. A parameter sets the shape of this network:

- One serial chain, running from the lowest bank upward. Every stage passes on either its own bank's word or the word arriving from the stage below.
- Several chains of limited height, whose outputs are joined by a binary mux tree.
- A pure mux tree with no chaining.

Every shape gives exactly the same cycle behaviour. An optional output register, with its own load enable and a synchronous clear, trades one cycle of latency for a shorter output path. The port carries no flow control: an access is issued in any cycle the port enable is high.

Top module: `deep_bank_mem`

## Requirements
- R1: Address bits [ADDR_W-1 -: log2(NUM_BANKS)] select the bank and the lower bits select the word in it. Every address of the full depth (4096 by default, as four banks of 1024 36-bit words) stores its own word.
- R2: With OUT_REG=0, a read issued at clock edge k (port_en=1, wr_en=0) shows its word on rd_data after edge k.
- R3: With OUT_REG=1 and out_ce high, a read issued at edge k shows its word on rd_data after edge k+1. During the cycle between those edges, rd_data still shows the previous value.
- R4: A write cycle (port_en=1, wr_en=1) does not change the read path. The output keeps the last word read.
- R5: With port_en low, the memory is not written and the read path keeps its value, whatever wr_en, addr and wr_data carry.
- R6: When out_rst is high at an edge, rd_data is zero after that edge. The memory contents are left unchanged. out_rst only affects the output register, so with OUT_REG=0 it has no effect.
- R7: When out_ce is low and out_rst is low, the output register holds its value. When out_rst and out_ce are both high, the clear wins.
- R8: A write changes only the addressed bank. The word at the same in-bank index in every other bank is left unchanged.
- R9: Before any write, every word reads as zero, and rd_data starts at zero.
- R10: The CHAIN_H parameter sets the merge shape:
  - 0 builds a pure mux tree.
  - A value of NUM_BANKS or more builds one serial chain.
  - Values in between build chains of that height, with the last chain possibly shorter, joined by a mux tree.

  All of these shapes return identical data in identical cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, rising edge |
| port_en | input | 1 | Port enable; gates every read and write |
| wr_en | input | 1 | 1 = write cycle, 0 = read cycle (while port_en is high) |
| addr | input | ADDR_W | Word address; upper bits choose the bank |
| wr_data | input | DATA_W | Data to write |
| out_rst | input | 1 | Synchronous clear of the output register |
| out_ce | input | 1 | Load enable of the output register |
| rd_data | output | DATA_W | Read data |

## Verification
If the registered bank index goes wrong, the bench sees a word from another bank at the in-bank index it addressed. This shows on rd_data one cycle after the read with OUT_REG=0, or two cycles after with OUT_REG=1. A bank read register that updates on writes or idle cycles breaks the hold behaviour in the very next cycle, so it is caught even when no read follows. A fault in a chain stage or a tree node only affects the banks routed through it. For that reason the bench runs chain, tree, mixed and uneven-chain instances against one flat reference model, using accesses that spread over every bank.

// File: rtl/deep_bank_pkg.sv
package deep_bank_pkg;

  // Height of one serial chain after clamping (0 means a tree of single banks).
  function automatic int chain_len(input int banks, input int height);
    if (height <= 0) return 1;
    if (height > banks) return banks;
    return height;
  endfunction

  // Number of chains that together cover all banks.
  function automatic int group_cnt(input int banks, input int height);
    int len;
    len = chain_len(banks, height);
    return (banks + len - 1) / len;
  endfunction

  // Bits needed to index n items, never less than one.
  function automatic int idx_bits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/dbm_bank.sv
module dbm_bank #(
  parameter int DATA_W = 36,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              hit,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << IDX_W;

  logic [DATA_W-1:0] store [WORDS];
  logic [DATA_W-1:0] rd_q = '0;

  initial begin
    for (int i = 0; i < WORDS; i++) store[i] = '0;
  end

  // No-change: a write leaves the read register alone.
  always_ff @(posedge clk) begin
    if (hit) begin
      if (wr) store[idx] <= wdata;
      else    rd_q       <= store[idx];
    end
  end

  assign rdata = rd_q;
endmodule

// File: rtl/dbm_merge.sv
module dbm_merge
  import deep_bank_pkg::*;
#(
  parameter int DATA_W    = 36,
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int CHAIN_H   = 4
) (
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_data,
  input  logic [BANK_W-1:0]                sel,
  output logic [DATA_W-1:0]                merged
);
  localparam int LEN = chain_len(NUM_BANKS, CHAIN_H);
  localparam int NG  = group_cnt(NUM_BANKS, CHAIN_H);
  localparam int GW  = idx_bits(NG);
  localparam int TN  = 1 << GW;

  logic [DATA_W-1:0] grp_out [NG];
  logic [GW-1:0]     gidx;

  assign gidx = GW'(int'(sel) / LEN);

  // Serial chains, lowest bank of each group first.
  for (genvar g = 0; g < NG; g++) begin : chain
    for (genvar k = 0; k < LEN; k++) begin : stg
      localparam int B = g * LEN + k;
      logic [DATA_W-1:0] v;
      if (k == 0) begin : g_base
        assign v = bank_data[B];
      end else if (B < NUM_BANKS) begin : g_pick
        assign v = (sel == BANK_W'(B)) ? bank_data[B] : chain[g].stg[k-1].v;
      end else begin : g_pass
        assign v = chain[g].stg[k-1].v;
      end
    end
    assign grp_out[g] = chain[g].stg[LEN-1].v;
  end

  // Binary tree over chain outputs, leaves first.
  for (genvar lv = GW; lv >= 0; lv--) begin : lvl
    for (genvar j = 0; j < (1 << lv); j++) begin : nd
      logic [DATA_W-1:0] v;
      if (lv == GW) begin : g_leaf
        if (j < NG) begin : g_real
          assign v = grp_out[j];
        end else begin : g_pad
          assign v = grp_out[0];
        end
      end else begin : g_mux
        assign v = gidx[GW-1-lv] ? lvl[lv+1].nd[2*j+1].v : lvl[lv+1].nd[2*j].v;
      end
    end
  end

  assign merged = lvl[0].nd[0].v;

  if (TN != 2 * NG && NG == 1) begin : g_unused
    logic unused_gidx;
    assign unused_gidx = ^gidx;
  end
endmodule

// File: rtl/dbm_outstage.sv
module dbm_outstage #(
  parameter int DATA_W  = 36,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  if (OUT_REG) begin : g_reg
    logic [DATA_W-1:0] q = '0;
    always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (ce) q <= din;
    end
    assign dout = q;
  end else begin : g_comb
    logic unused_ctl;
    assign unused_ctl = rst ^ ce;
    assign dout = din;
  end
endmodule

// File: rtl/deep_bank_mem.sv
module deep_bank_mem
  import deep_bank_pkg::*;
#(
  parameter int DATA_W    = 36,
  parameter int ADDR_W    = 12,
  parameter int NUM_BANKS = 4,
  parameter int CHAIN_H   = 4,
  parameter bit OUT_REG   = 1'b1
) (
  input  logic              clk,
  input  logic              port_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              out_rst,
  input  logic              out_ce,
  output logic [DATA_W-1:0] rd_data
);
  localparam int BANK_W = idx_bits(NUM_BANKS);
  localparam int IDX_W  = ADDR_W - BANK_W;

  logic [BANK_W-1:0]               bank_sel;
  logic [IDX_W-1:0]                word_idx;
  logic [NUM_BANKS-1:0]            bank_hit;
  logic [NUM_BANKS-1:0]            bank_we_w;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd;
  logic [BANK_W-1:0]               sel_q = '0;
  logic [DATA_W-1:0]               merged_w;

  assign bank_sel = addr[ADDR_W-1 -: BANK_W];
  assign word_idx = addr[IDX_W-1:0];

  // Bank index follows its read so the merge picks the matching bank.
  always_ff @(posedge clk) begin
    if (port_en && !wr_en) sel_q <= bank_sel;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : bank
    assign bank_hit[b]  = port_en && (bank_sel == BANK_W'(b));
    assign bank_we_w[b] = bank_hit[b] && wr_en;
    dbm_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
      .clk   (clk),
      .hit   (bank_hit[b]),
      .wr    (wr_en),
      .idx   (word_idx),
      .wdata (wr_data),
      .rdata (bank_rd[b])
    );
  end

  dbm_merge #(
    .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .CHAIN_H(CHAIN_H)
  ) u_merge (
    .bank_data (bank_rd),
    .sel       (sel_q),
    .merged    (merged_w)
  );

  dbm_outstage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
    .clk  (clk),
    .rst  (out_rst),
    .ce   (out_ce),
    .din  (merged_w),
    .dout (rd_data)
  );
endmodule

// File: rtl/deep_bank_mem_chk.sv
module deep_bank_mem_chk #(
  parameter int DATA_W    = 36,
  parameter int NUM_BANKS = 4,
  parameter bit OUT_REG   = 1'b1
) (
  input logic                 clk,
  input logic                 port_en,
  input logic                 wr_en,
  input logic                 out_rst,
  input logic                 out_ce,
  input logic [DATA_W-1:0]    rd_data,
  input logic [DATA_W-1:0]    merged,
  input logic [NUM_BANKS-1:0] bank_we
);
  // R4
  write_holds_chk: assert property (@(posedge clk) disable iff (out_rst)
    (port_en && wr_en) |=> $stable(merged));

  // R5
  idle_holds_chk: assert property (@(posedge clk) disable iff (out_rst)
    !port_en |=> $stable(merged));

  // R8
  one_bank_write_chk: assert property (@(posedge clk) disable iff (out_rst)
    $onehot0(bank_we));

  if (OUT_REG) begin : g_reg_chk
    // R6
    out_clear_chk: assert property (@(posedge clk)
      out_rst |=> (rd_data == '0));

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (out_rst)
      !out_ce |=> $stable(rd_data));

    // R3
    out_load_chk: assert property (@(posedge clk) disable iff (out_rst)
      out_ce |=> (rd_data == $past(merged)));
  end
endmodule

bind deep_bank_mem deep_bank_mem_chk #(
  .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .OUT_REG(OUT_REG)
) chk_i (
  .clk     (clk),
  .port_en (port_en),
  .wr_en   (wr_en),
  .out_rst (out_rst),
  .out_ce  (out_ce),
  .rd_data (rd_data),
  .merged  (merged_w),
  .bank_we (bank_we_w)
);

// File: tb/deep_bank_mem_tb_top.sv
module deep_bank_mem_tb_top;
  localparam int DW = 36;
  localparam int AW = 12;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{1'b1, 12'h000, 36'h1_0000_0001}, '{1'b1, 12'h3FF, 36'h2_0000_03FF},
    '{1'b1, 12'h400, 36'h3_0000_0400}, '{1'b1, 12'h7FF, 36'h4_0000_07FF},
    '{1'b1, 12'h800, 36'h5_0000_0800}, '{1'b1, 12'hBFF, 36'h6_0000_0BFF},
    '{1'b1, 12'hC00, 36'h7_0000_0C00}, '{1'b1, 12'hFFF, 36'h8_0000_0FFF},
    '{1'b0, 12'hFFF, 36'h0},           '{1'b0, 12'h000, 36'h0},
    '{1'b0, 12'hC00, 36'h0},           '{1'b0, 12'h3FF, 36'h0},
    '{1'b0, 12'h800, 36'h0},           '{1'b0, 12'h7FF, 36'h0},
    '{1'b0, 12'hBFF, 36'h0},           '{1'b0, 12'h400, 36'h0}
  };

  logic          clk = 1'b0;
  logic          port_en = 1'b0, wr_en = 1'b0, out_rst = 1'b1, out_ce = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_full, rd_tree, rd_mix, rd_odd, rd_fast;

  logic [DW-1:0] model [1 << AW];
  logic [DW-1:0] m_exp = '0;
  logic [DW-1:0] r_exp = '0;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  deep_bank_mem #(.CHAIN_H(4), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .port_en(port_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .out_rst(out_rst), .out_ce(out_ce), .rd_data(rd_full));
  deep_bank_mem #(.CHAIN_H(0), .OUT_REG(1'b1)) dut_tree (
    .clk(clk), .port_en(port_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .out_rst(out_rst), .out_ce(out_ce), .rd_data(rd_tree));
  deep_bank_mem #(.CHAIN_H(2), .OUT_REG(1'b1)) dut_mix (
    .clk(clk), .port_en(port_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .out_rst(out_rst), .out_ce(out_ce), .rd_data(rd_mix));
  deep_bank_mem #(.CHAIN_H(3), .OUT_REG(1'b1)) dut_odd (
    .clk(clk), .port_en(port_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .out_rst(out_rst), .out_ce(out_ce), .rd_data(rd_odd));
  deep_bank_mem #(.CHAIN_H(2), .OUT_REG(1'b0)) dut_fast (
    .clk(clk), .port_en(port_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .out_rst(out_rst), .out_ce(out_ce), .rd_data(rd_fast));

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                     input string tag, input string who);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, who, act, exp, $time);
    end
  endtask

  // Drive at a falling edge, update the reference at the rising edge,
  // compare at the next falling edge.
  task automatic step(input logic e, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic r, input logic c,
                      input string tag);
    port_en = e; wr_en = w; addr = a; wr_data = d; out_rst = r; out_ce = c;
    @(posedge clk);
    if (r)      r_exp = '0;
    else if (c) r_exp = m_exp;
    if (e) begin
      if (w) model[a] = d;
      else   m_exp = model[a];
    end
    @(negedge clk);
    chk(rd_full, r_exp, tag, "single chain");
    chk(rd_tree, r_exp, tag, "pure tree");
    chk(rd_mix,  r_exp, tag, "chains of 2");
    chk(rd_odd,  r_exp, tag, "chains of 3");
    chk(rd_fast, m_exp, tag, "unregistered");
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    @(negedge clk);

    // R9 and R6: reset state, output cleared, unwritten words read zero
    step(1'b0, 1'b0, 12'h000, '0, 1'b1, 1'b1, "R6 reset state");
    step(1'b1, 1'b0, 12'h9A5, '0, 1'b0, 1'b1, "R9 unwritten read");
    step(1'b0, 1'b0, 12'h000, '0, 1'b0, 1'b1, "R9 unwritten read");

    // R1: table walk across bank boundaries, R2/R3 latencies checked each step
    for (int v = 0; v < 16; v++)
      step(1'b1, VECS[v].wr, VECS[v].a, VECS[v].d, 1'b0, 1'b1, "R1 table");
    step(1'b0, 1'b0, 12'h000, '0, 1'b0, 1'b1, "R3 trailing read");

    // R2 / R3: back-to-back reads from different banks
    step(1'b1, 1'b0, 12'h3FF, '0, 1'b0, 1'b1, "R2 R3 latency");
    step(1'b1, 1'b0, 12'hC00, '0, 1'b0, 1'b1, "R2 R3 latency");
    step(1'b0, 1'b0, 12'h000, '0, 1'b0, 1'b1, "R3 latency");

    // R4: writes do not disturb the read path
    step(1'b1, 1'b1, 12'h555, 36'hA_BCDE_F012, 1'b0, 1'b1, "R4 no-change");
    step(1'b1, 1'b1, 12'h556, 36'h1_1111_1111, 1'b0, 1'b1, "R4 no-change");
    step(1'b1, 1'b1, 12'hC00, 36'h9_9999_9999, 1'b0, 1'b1, "R4 no-change");

    // R5: disabled port ignores a write and a read
    step(1'b0, 1'b1, 12'h3FF, 36'hF_FFFF_FFFF, 1'b0, 1'b1, "R5 disabled write");
    step(1'b0, 1'b0, 12'h800, '0, 1'b0, 1'b1, "R5 disabled read");
    step(1'b1, 1'b0, 12'h3FF, '0, 1'b0, 1'b1, "R5 word kept");
    step(1'b0, 1'b0, 12'h000, '0, 1'b0, 1'b1, "R5 word kept");

    // R7: enable low holds, then loads; clear wins over enable
    step(1'b1, 1'b0, 12'h555, '0, 1'b0, 1'b0, "R7 hold");
    step(1'b0, 1'b0, 12'h000, '0, 1'b0, 1'b0, "R7 hold");
    step(1'b0, 1'b0, 12'h000, '0, 1'b0, 1'b1, "R7 load");
    step(1'b0, 1'b0, 12'h000, '0, 1'b1, 1'b1, "R7 clear priority");

    // R6: clear leaves memory intact
    step(1'b1, 1'b0, 12'h555, '0, 1'b0, 1'b1, "R6 memory kept");
    step(1'b0, 1'b0, 12'h000, '0, 1'b0, 1'b1, "R6 memory kept");

    // R8: write bank 2 at index 5, other banks at index 5 unchanged
    step(1'b1, 1'b1, 12'h805, 36'h7_7777_7777, 1'b0, 1'b1, "R8 bank write");
    step(1'b1, 1'b0, 12'h005, '0, 1'b0, 1'b1, "R8 other bank");
    step(1'b1, 1'b0, 12'h405, '0, 1'b0, 1'b1, "R8 other bank");
    step(1'b1, 1'b0, 12'hC05, '0, 1'b0, 1'b1, "R8 other bank");
    step(1'b1, 1'b0, 12'h805, '0, 1'b0, 1'b1, "R8 own bank");
    step(1'b0, 1'b0, 12'h000, '0, 1'b0, 1'b1, "R8 own bank");

    // R10: random traffic, every merge shape against the flat reference
    begin
      void'($urandom(32'h5EED));
      for (int n = 0; n < 3000; n++) begin
        logic [1:0]  bk;
        logic [2:0]  lo;
        logic [DW-1:0] dd;
        bk = 2'($urandom);
        lo = 3'($urandom);
        dd = {4'($urandom), $urandom};
        step(($urandom % 10) != 0, ($urandom % 5) < 2, {bk, 7'd0, lo}, dd,
             ($urandom % 32) == 0, ($urandom % 7) != 0, "R10 random");
      end
    end

    summary();
    $finish;
  end
endmodule